// File: doc/BRIEF.md
# Strap-Configured GPIO Pin Multiplexer

This block runs five general-purpose pins for a bus-interface chip. Every pin has a direction bit and an output data bit, which software reaches through a small register port. A control register can hand pin 0 and pin 1 to internal status signals. Pin 0 can show an activity indicator or a hint that the next bus request is an opcode fetch. Pin 1 can show bus ownership. The register port also returns the live level seen on every pad.

A strap input is captured while reset is held. When the captured strap is set, pins 0 and 1 become the data and clock lines of a serial EEPROM for as long as the download engine reports that it is busy. This takeover beats every control-register function. The pads themselves, their drive strength and the download engine live outside the block. The block only decides, pin by pin, the output value and the output enable.

Top module: `gpio_strap_mux`

## Requirements
- R1: After reset, the direction bits are 5'b10000 (1 = output, bit n is pin n), the data bits and the control register are all zero, so pad_oe is 5'b10000 and pad_out is 5'b00000 while the download flag is low.
- R2: Writes with reg_we high store reg_wdata at address 0 (direction, bits 4:0), address 1 (output data, bits 4:0) and address 2 (control, bits 7:5 only), and a read at the same address returns the stored value with every unused bit read as 0. Writes made while reset is held have no effect.
- R3: Address 3 reads back pad_in in bits 4:0 at any time, whatever the direction bits hold. A write to address 3 changes no register and no output.
- R4: A pin with no special function active drives pad_oe[n] from its direction bit and pad_out[n] from its data bit.
- R5: The strap is taken from strap_ee during reset and held from then on. A change of strap_ee after reset has no effect until the next reset.
- R6: With the captured strap set and ee_busy high, pin 0 outputs ee_sda_out with enable ee_sda_oe and pin 1 outputs ee_scl_out with enable 1. This holds whatever the control bits are.
- R7: With control bit 5 set, bit 6 clear, no EEPROM takeover and ee_busy low, pin 0 is enabled and outputs act_led. While ee_busy is high, bit 5 has no effect, even with the strap clear.
- R8: With control bit 6 set and no EEPROM takeover, pin 0 is enabled and outputs fetch_hint. Bit 6 wins over bit 5.
- R9: With control bit 7 set and no EEPROM takeover, pin 1 is enabled and outputs the inverse of is_master, so it is low while the device owns the bus.
- R10: Pins 2 to 4 always follow their own direction and data bits, whatever the strap, the download flag or the control bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 direction, 1 data, 2 control, 3 pad level) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| strap_ee | input | 1 | Strap that selects the EEPROM use of pins 0 and 1, captured during reset |
| ee_busy | input | 1 | EEPROM download in progress |
| ee_sda_out | input | 1 | EEPROM data value from the download engine |
| ee_sda_oe | input | 1 | EEPROM data drive enable from the download engine |
| ee_scl_out | input | 1 | EEPROM clock from the download engine |
| act_led | input | 1 | Activity status for the indicator on pin 0 |
| fetch_hint | input | 1 | Next bus request is an opcode fetch |
| is_master | input | 1 | Device currently owns the bus |
| pad_in | input | 5 | Live pad input levels |
| pad_out | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables |

## Verification
The main vector walk sets the direction, data and control registers and then checks pad_out and pad_oe under several patterns. Plain direction and data patterns show that the register path works. The indicator bits are tried one at a time and then together, which shows the priority of the opcode-fetch hint over the activity indicator. The download flag is raised with the strap set and with it clear, which separates the full EEPROM takeover from the plain suppression of the indicator. Directed tests cover the reset values, the masking on readback, a write to the pad-level address, and a strap that changes after reset.

// File: rtl/gpio_strap_pkg.sv
package gpio_strap_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // control register bit positions visible to software
    localparam int CTL_LED_BIT    = 5;
    localparam int CTL_FETCH_BIT  = 6;
    localparam int CTL_MASTER_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_PADS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic master_ind;
        logic fetch_ind;
        logic led_ind;
    } pin_ctl_t;

    typedef enum logic [2:0] {
        SRC_REG,
        SRC_EEPROM,
        SRC_FETCH,
        SRC_LED,
        SRC_MASTER
    } pin_src_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    // pin 0 source: EEPROM takeover, then fetch hint, then activity indicator
    function automatic pin_src_e pick_pin0(logic claim, logic busy, pin_ctl_t c);
        if (claim)                  return SRC_EEPROM;
        if (c.fetch_ind)            return SRC_FETCH;
        if (c.led_ind && !busy)     return SRC_LED;
        return SRC_REG;
    endfunction

    // pin 1 source: EEPROM takeover, then bus-ownership indicator
    function automatic pin_src_e pick_pin1(logic claim, pin_ctl_t c);
        if (claim)          return SRC_EEPROM;
        if (c.master_ind)   return SRC_MASTER;
        return SRC_REG;
    endfunction

endpackage

// File: rtl/gpio_strap_regs.sv
module gpio_strap_regs
    import gpio_strap_pkg::*;
#(
    parameter int NPINS = 5,
    parameter logic [NPINS-1:0] DIR_RST = {1'b1, {(NPINS-1){1'b0}}}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NPINS-1:0]    pad_in,
    input  logic                strap_in,
    output logic [NPINS-1:0]    dir_q,
    output logic [NPINS-1:0]    dat_q,
    output pin_ctl_t            ctl_q,
    output logic                strap_q,
    output logic [REG_W-1:0]    rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= DIR_RST;
            dat_q   <= '0;
            ctl_q   <= '0;
            strap_q <= strap_in;
        end else if (we) begin
            unique case (sel)
                SEL_DIR:  dir_q <= wdata[NPINS-1:0];
                SEL_DATA: dat_q <= wdata[NPINS-1:0];
                SEL_CTRL: begin
                    ctl_q.led_ind    <= wdata[CTL_LED_BIT];
                    ctl_q.fetch_ind  <= wdata[CTL_FETCH_BIT];
                    ctl_q.master_ind <= wdata[CTL_MASTER_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_DIR:  rdata[NPINS-1:0] = dir_q;
            SEL_DATA: rdata[NPINS-1:0] = dat_q;
            SEL_CTRL: begin
                rdata[CTL_LED_BIT]    = ctl_q.led_ind;
                rdata[CTL_FETCH_BIT]  = ctl_q.fetch_ind;
                rdata[CTL_MASTER_BIT] = ctl_q.master_ind;
            end
            default:  rdata[NPINS-1:0] = pad_in;
        endcase
    end

endmodule

// File: rtl/gpio_strap_arbiter.sv
module gpio_strap_arbiter
    import gpio_strap_pkg::*;
(
    input  logic     strap_q,
    input  logic     ee_busy,
    input  pin_ctl_t ctl_q,
    output logic     ee_claim,
    output pin_src_e src0,
    output pin_src_e src1
);

    assign ee_claim = strap_q & ee_busy;
    assign src0     = pick_pin0(ee_claim, ee_busy, ctl_q);
    assign src1     = pick_pin1(ee_claim, ctl_q);

endmodule

// File: rtl/gpio_strap_drive.sv
module gpio_strap_drive
    import gpio_strap_pkg::*;
#(
    parameter int NPINS = 5
) (
    input  pin_src_e          src0,
    input  pin_src_e          src1,
    input  logic [NPINS-1:0]  dir_q,
    input  logic [NPINS-1:0]  dat_q,
    input  logic              ee_sda_out,
    input  logic              ee_sda_oe,
    input  logic              ee_scl_out,
    input  logic              act_led,
    input  logic              fetch_hint,
    input  logic              is_master,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_drive_t drv;
        if (i == 0) begin : g_data_pin
            always_comb begin
                unique case (src0)
                    SRC_EEPROM: drv = '{oe: ee_sda_oe, val: ee_sda_out};
                    SRC_FETCH:  drv = '{oe: 1'b1,      val: fetch_hint};
                    SRC_LED:    drv = '{oe: 1'b1,      val: act_led};
                    default:    drv = '{oe: dir_q[i],  val: dat_q[i]};
                endcase
            end
        end else if (i == 1) begin : g_clock_pin
            always_comb begin
                unique case (src1)
                    SRC_EEPROM: drv = '{oe: 1'b1,     val: ee_scl_out};
                    SRC_MASTER: drv = '{oe: 1'b1,     val: ~is_master};
                    default:    drv = '{oe: dir_q[i], val: dat_q[i]};
                endcase
            end
        end else begin : g_plain_pin
            assign drv = '{oe: dir_q[i], val: dat_q[i]};
        end
        assign pad_out[i] = drv.val;
        assign pad_oe[i]  = drv.oe;
    end

endmodule

// File: rtl/gpio_strap_mux.sv
module gpio_strap_mux
    import gpio_strap_pkg::*;
#(
    parameter int NPINS = 5,
    parameter logic [NPINS-1:0] DIR_RST = {1'b1, {(NPINS-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              strap_ee,
    input  logic              ee_busy,
    input  logic              ee_sda_out,
    input  logic              ee_sda_oe,
    input  logic              ee_scl_out,
    input  logic              act_led,
    input  logic              fetch_hint,
    input  logic              is_master,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] dat_q;
    pin_ctl_t         ctl_q;
    logic             strap_q;
    logic             ee_claim;
    pin_src_e         src0;
    pin_src_e         src1;

    gpio_strap_regs #(.NPINS(NPINS), .DIR_RST(DIR_RST)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pad_in   (pad_in),
        .strap_in (strap_ee),
        .dir_q    (dir_q),
        .dat_q    (dat_q),
        .ctl_q    (ctl_q),
        .strap_q  (strap_q),
        .rdata    (reg_rdata)
    );

    gpio_strap_arbiter u_arb (
        .strap_q  (strap_q),
        .ee_busy  (ee_busy),
        .ctl_q    (ctl_q),
        .ee_claim (ee_claim),
        .src0     (src0),
        .src1     (src1)
    );

    gpio_strap_drive #(.NPINS(NPINS)) u_drive (
        .src0       (src0),
        .src1       (src1),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .ee_sda_out (ee_sda_out),
        .ee_sda_oe  (ee_sda_oe),
        .ee_scl_out (ee_scl_out),
        .act_led    (act_led),
        .fetch_hint (fetch_hint),
        .is_master  (is_master),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

endmodule

// File: rtl/gpio_strap_mux_chk.sv
module gpio_strap_mux_chk
    import gpio_strap_pkg::*;
#(
    parameter int NPINS = 5,
    parameter logic [NPINS-1:0] DIR_RST = {1'b1, {(NPINS-1){1'b0}}}
) (
    input logic             clk,
    input logic             rst,
    input logic             strap_q,
    input logic             ee_busy,
    input pin_ctl_t         ctl_q,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] dat_q,
    input logic             ee_sda_oe,
    input logic             ee_scl_out,
    input logic             fetch_hint,
    input logic             is_master,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe
);

    // R1: pins 2 and up leave reset with their reset direction and low data
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pad_oe[NPINS-1:2] == DIR_RST[NPINS-1:2]) && (pad_out[NPINS-1:2] == '0));

    // R5: captured strap never moves outside reset
    a_r5_strap_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_q));

    // R6: EEPROM takeover of both pins
    a_r6_ee_takeover: assert property (@(posedge clk) disable iff (rst)
        (strap_q && ee_busy) |->
            pad_oe[1] && (pad_out[1] == ee_scl_out) && (pad_oe[0] == ee_sda_oe));

    // R7: indicator suppressed during a download unless the fetch hint holds pin 0
    a_r7_led_quiet: assert property (@(posedge clk) disable iff (rst)
        (ee_busy && !strap_q && !ctl_q.fetch_ind) |->
            (pad_oe[0] == dir_q[0]) && (pad_out[0] == dat_q[0]));

    // R8: fetch hint owns pin 0 when there is no takeover
    a_r8_fetch_first: assert property (@(posedge clk) disable iff (rst)
        (!(strap_q && ee_busy) && ctl_q.fetch_ind) |->
            pad_oe[0] && (pad_out[0] == fetch_hint));

    // R9: pin 1 low while bus master
    a_r9_master_low: assert property (@(posedge clk) disable iff (rst)
        (!(strap_q && ee_busy) && ctl_q.master_ind && is_master) |->
            pad_oe[1] && !pad_out[1]);

    // R10: upper pins follow their registers
    a_r10_plain_pins: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[NPINS-1:2] == dir_q[NPINS-1:2]) && (pad_out[NPINS-1:2] == dat_q[NPINS-1:2]));

endmodule

bind gpio_strap_mux gpio_strap_mux_chk #(.NPINS(NPINS), .DIR_RST(DIR_RST)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strap_q    (strap_q),
    .ee_busy    (ee_busy),
    .ctl_q      (ctl_q),
    .dir_q      (dir_q),
    .dat_q      (dat_q),
    .ee_sda_oe  (ee_sda_oe),
    .ee_scl_out (ee_scl_out),
    .fetch_hint (fetch_hint),
    .is_master  (is_master),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/test_gpio_strap_mux.sv
module test_gpio_strap_mux;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       strap_ee = 1'b0;
    logic       ee_busy = 1'b0;
    logic       ee_sda_out = 1'b0;
    logic       ee_sda_oe = 1'b0;
    logic       ee_scl_out = 1'b0;
    logic       act_led = 1'b0;
    logic       fetch_hint = 1'b0;
    logic       is_master = 1'b0;
    logic [4:0] pad_in = '0;
    logic [4:0] pad_out;
    logic [4:0] pad_oe;

    always #2 clk = ~clk;

    gpio_strap_mux i_gpio_strap_mux (.*);

    int applied = 0;
    int missed  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic [3:0] req;
        logic       strap;
        logic [7:0] ctl;
        logic [4:0] dir;
        logic [4:0] dat;
        logic       busy;
        logic       sda_o;
        logic       sda_oe;
        logic       scl;
        logic       act;
        logic       fetch;
        logic       master;
        logic [4:0] exp_out;
        logic [4:0] exp_oe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        //  req  strap ctl    dir       dat       busy sdao sdaoe scl act fetch mst  out       oe
        '{4'd4, 1'b0, 8'h00, 5'b10101, 5'b11011, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 5'b11011, 5'b10101}, // R4
        '{4'd4, 1'b0, 8'h00, 5'b01010, 5'b00100, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 5'b00100, 5'b01010}, // R4
        '{4'd7, 1'b0, 8'h20, 5'b00000, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 5'b00001, 5'b00001}, // R7
        '{4'd7, 1'b0, 8'h20, 5'b00000, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 5'b00000, 5'b00001}, // R7
        '{4'd7, 1'b0, 8'h20, 5'b00001, 5'b00000, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 5'b00000, 5'b00001}, // R7 busy
        '{4'd8, 1'b0, 8'h60, 5'b00000, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 5'b00000, 5'b00001}, // R8
        '{4'd8, 1'b0, 8'h40, 5'b00000, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 5'b00001, 5'b00001}, // R8
        '{4'd9, 1'b0, 8'h80, 5'b00000, 5'b00010, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 5'b00000, 5'b00010}, // R9
        '{4'd9, 1'b0, 8'h80, 5'b00000, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 5'b00010, 5'b00010}, // R9
        '{4'd6, 1'b1, 8'hE0, 5'b11100, 5'b00000, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 5'b00011, 5'b11110}, // R6
        '{4'd6, 1'b1, 8'h00, 5'b00000, 5'b11111, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 5'b11100, 5'b00011}, // R6
        '{4'd8, 1'b1, 8'hC0, 5'b00000, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 5'b00011, 5'b00011}, // R8 R9 no download
        '{4'd10,1'b1, 8'hE0, 5'b00000, 5'b10100, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 5'b10100, 5'b00010}  // R10
    };

    task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
        applied++;
        if (got !== exp) begin
            missed++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset(logic s);
        @(negedge clk);
        rst = 1'b1;
        strap_ee = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, missed);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            missed++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;

        // R1: reset state, written during reset too
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hFF;
        @(negedge clk);
        reg_we = 1'b0;
        do_reset(1'b0);
        @(negedge clk);
        check("R1", "pad_oe", {3'b0, pad_oe}, 8'h10);
        check("R1", "pad_out", {3'b0, pad_out}, 8'h00);
        rd(2'd0, d); check("R1", "dir", d, 8'h10);
        rd(2'd1, d); check("R2", "data after write in reset", d, 8'h00);
        rd(2'd2, d); check("R1", "ctrl", d, 8'h00);

        // R2: masking of unused bits
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R2", "dir", d, 8'h1F);
        wr(2'd1, 8'hAA); rd(2'd1, d); check("R2", "data", d, 8'h0A);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R2", "ctrl", d, 8'hE0);
        wr(2'd2, 8'h00);

        // R3: live pad level, writes ignored
        wr(2'd0, 8'h03);
        pad_in = 5'b10110;
        rd(2'd3, d); check("R3", "pads", d, 8'h16);
        pad_in = 5'b01001;
        rd(2'd3, d); check("R3", "pads live", d, 8'h09);
        wr(2'd3, 8'hFF);
        @(negedge clk);
        check("R3", "pad_oe after pad write", {3'b0, pad_oe}, 8'h03);
        check("R3", "pad_out after pad write", {3'b0, pad_out}, 8'h0A);
        rd(2'd0, d); check("R3", "dir after pad write", d, 8'h03);

        // R5: strap held from reset
        do_reset(1'b0);
        strap_ee = 1'b1; ee_busy = 1'b1; ee_scl_out = 1'b1;
        @(negedge clk);
        check("R5", "pad_oe no takeover", {3'b0, pad_oe}, 8'h10);
        do_reset(1'b1);
        strap_ee = 1'b0;
        @(negedge clk);
        check("R5", "pad_oe takeover kept", {3'b0, pad_oe}, 8'h12);
        check("R5", "pad_out takeover kept", {3'b0, pad_out}, 8'h02);
        ee_busy = 1'b0; ee_scl_out = 1'b0;

        // vector walk
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string tag;
            v = VECS[k];
            tag = $sformatf("R%0d vec%0d", v.req, k);
            ee_busy = 1'b0;
            do_reset(v.strap);
            wr(2'd0, {3'b0, v.dir});
            wr(2'd1, {3'b0, v.dat});
            wr(2'd2, v.ctl);
            @(negedge clk);
            ee_busy = v.busy; ee_sda_out = v.sda_o; ee_sda_oe = v.sda_oe;
            ee_scl_out = v.scl; act_led = v.act; fetch_hint = v.fetch; is_master = v.master;
            @(negedge clk);
            check(tag, "pad_out", {3'b0, pad_out}, {3'b0, v.exp_out});
            check(tag, "pad_oe", {3'b0, pad_oe}, {3'b0, v.exp_oe});
        end

        done = 1'b1;
        finish_run();
    end

endmodule